// File: doc/BRIEF.md
# Serial NOR Flash Probe and Unlock Sequencer

This block runs once at start-up, or whenever software-free boot logic asks it to. It learns which serial NOR flash sits on an SPI link and, if the part is known, lifts its power-on write protection. The block never drives SPI bits itself. It hands one byte at a time to a serializer through a request/acknowledge exchange, and it owns the chip-select line that frames each transaction.

On a start pulse the block frames one identify transaction. That transaction holds the identify opcode followed by three filler bytes, and the replies to the filler bytes are captured as the manufacturer, memory-type and capacity codes. A decoder checks the first two codes against fixed values and turns the capacity code into a geometry: sector count, sector shift, page count and page shift. If the part is recognised, three single-byte transactions follow, each framed on its own: write enable, global protection unlock, write disable. The block then pulses `done_o`, with `ok_o` telling success from failure.

The states are IDLE, ID_XFER, ID_GAP, DECIDE, CMD_XFER, CMD_GAP and FINISH. The transitions are:
- IDLE→ID_XFER on start.
- ID_XFER→ID_GAP on the acknowledge of the fourth byte.
- ID_GAP→DECIDE always.
- DECIDE→CMD_XFER when the ID matches, DECIDE→FINISH when it does not.
- CMD_XFER→CMD_GAP on acknowledge.
- CMD_GAP→CMD_XFER while commands remain, CMD_GAP→FINISH after the third.
- FINISH→IDLE always.

Top module: `flash_probe_ctrl`

## Requirements
- R1: After reset, `cs_n_o` is high, `xfer_req_o`, `done_o` and `ok_o` are low, and all geometry outputs are zero; `cs_n_o` stays high while no sequence runs.
- R2: The identify transaction is one chip-select frame of four bytes: 0x9F, then 0xA5 three times.
- R3: The bytes received in positions 2, 3 and 4 of the identify frame are taken as manufacturer, memory type and capacity code.
- R4: The part is accepted only if the manufacturer is 0xBF and the memory type is 0x26. Otherwise the run ends with `ok_o` low, geometry zero and no further frames.
- R5: Each capacity code sets its own counts: 0x41 gives 512 sectors and 8192 pages, 0x42 gives 1024 sectors and 16384 pages, 0x43 gives 2048 sectors and 32768 pages. For all three, the sector shift is 12 and the page shift is 8.
- R6: Any other capacity code ends the run as an error with no unlock frames.
- R7: After acceptance, three one-byte frames follow in the order 0x06, 0x98, 0x04, with `cs_n_o` high between them. `cs_n_o` is high when `done_o` fires.
- R8: `done_o` is a one-cycle pulse after the last frame closes. `ok_o` gives the result at that pulse and holds it until the next accepted start.
- R9: A start pulse that arrives while a run is in progress has no effect.
- R10: `xfer_req_o` is high only while `cs_n_o` is low. Once raised, it and `xfer_tx_o` hold steady until `xfer_ack_i`.
- R11: Geometry outputs keep the last recognised part's values between runs and through a later run until its decision. A failed run clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the probe |
| xfer_req_o | output | 1 | Byte exchange request to the serializer |
| xfer_tx_o | output | 8 | Byte to shift out |
| xfer_ack_i | input | 1 | One-cycle completion of the current byte exchange |
| xfer_rx_i | input | 8 | Byte shifted in, valid with `xfer_ack_i` |
| cs_n_o | output | 1 | Active-low flash chip select |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Result of the last run (1 = recognised and unlocked) |
| sector_count_o | output | SECT_CNT_W | Number of erase sectors |
| sector_shift_o | output | SHIFT_W | log2 of the sector size in bytes |
| page_count_o | output | PAGE_CNT_W | Number of program pages |
| page_shift_o | output | SHIFT_W | log2 of the page size in bytes |

## Verification
The properties assume that the serializer raises `xfer_ack_i` only for a single cycle and only while `xfer_req_o` is high, and that `xfer_rx_i` is meaningful only alongside that acknowledge. The bench's serializer model obeys this. It waits a programmable number of cycles after seeing a request, pulses the acknowledge once, and drops it on the next cycle. Start pulses injected mid-run are sent only while chip select is low, so they always fall inside a busy window.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

    localparam logic [7:0] OP_IDENTIFY   = 8'h9F;
    localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
    localparam logic [7:0] OP_UNPROTECT  = 8'h98;
    localparam logic [7:0] OP_WR_DISABLE = 8'h04;
    localparam logic [7:0] FILLER_BYTE   = 8'hA5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID_XFER,
        ST_ID_GAP,
        ST_DECIDE,
        ST_CMD_XFER,
        ST_CMD_GAP,
        ST_FINISH
    } probe_state_t;

    function automatic logic [7:0] unlock_opcode(input logic [1:0] idx);
        case (idx)
            2'd0:    return OP_WR_ENABLE;
            2'd1:    return OP_UNPROTECT;
            default: return OP_WR_DISABLE;
        endcase
    endfunction

endpackage

// File: rtl/flash_id_decode.sv
module flash_id_decode #(
    parameter logic [7:0] MFR_CODE     = 8'hBF,
    parameter logic [7:0] TYPE_CODE    = 8'h26,
    parameter logic [7:0] BASE_CAP     = 8'h41,
    parameter int         NUM_SIZES    = 3,
    parameter int         BASE_SECTORS = 512,
    parameter int         BASE_PAGES   = 8192,
    parameter int         SECT_CNT_W   = 12,
    parameter int         PAGE_CNT_W   = 16
) (
    input  logic [7:0]            mfr_i,
    input  logic [7:0]            type_i,
    input  logic [7:0]            cap_i,
    output logic                  match_o,
    output logic [SECT_CNT_W-1:0] sect_cnt_o,
    output logic [PAGE_CNT_W-1:0] page_cnt_o
);
    logic [NUM_SIZES-1:0] size_hit;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        assign size_hit[g] = (cap_i == 8'(int'(BASE_CAP) + g));
    end

    always_comb begin
        sect_cnt_o = '0;
        page_cnt_o = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (size_hit[i]) begin
                sect_cnt_o = SECT_CNT_W'(BASE_SECTORS << i);
                page_cnt_o = PAGE_CNT_W'(BASE_PAGES << i);
            end
        end
    end

    assign match_o = (mfr_i == MFR_CODE) && (type_i == TYPE_CODE) && (|size_hit);

endmodule

// File: rtl/flash_geom_hold.sv
module flash_geom_hold #(
    parameter int SECT_CNT_W = 12,
    parameter int PAGE_CNT_W = 16,
    parameter int SHIFT_W    = 4,
    parameter int SECT_SHIFT = 12,
    parameter int PAGE_SHIFT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_ok_i,
    input  logic                  load_err_i,
    input  logic [SECT_CNT_W-1:0] sect_cnt_i,
    input  logic [PAGE_CNT_W-1:0] page_cnt_i,
    output logic [SECT_CNT_W-1:0] sect_cnt_o,
    output logic [SHIFT_W-1:0]    sect_shift_o,
    output logic [PAGE_CNT_W-1:0] page_cnt_o,
    output logic [SHIFT_W-1:0]    page_shift_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sect_cnt_o   <= '0;
            sect_shift_o <= '0;
            page_cnt_o   <= '0;
            page_shift_o <= '0;
        end else if (load_ok_i) begin
            sect_cnt_o   <= sect_cnt_i;
            sect_shift_o <= SHIFT_W'(SECT_SHIFT);
            page_cnt_o   <= page_cnt_i;
            page_shift_o <= SHIFT_W'(PAGE_SHIFT);
        end else if (load_err_i) begin
            sect_cnt_o   <= '0;
            sect_shift_o <= '0;
            page_cnt_o   <= '0;
            page_shift_o <= '0;
        end
    end

endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
    import flash_probe_pkg::*;
#(
    parameter int ID_BYTES = 3,
    parameter int NUM_CMDS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ack_i,
    input  logic [7:0] rx_i,
    input  logic       match_i,
    output logic       req_o,
    output logic [7:0] tx_o,
    output logic       cs_n_o,
    output logic       done_o,
    output logic       ok_o,
    output logic       load_ok_o,
    output logic       load_err_o,
    output logic [7:0] mfr_o,
    output logic [7:0] type_o,
    output logic [7:0] cap_o
);
    localparam int IDX_W = $clog2(ID_BYTES + 1);
    localparam int CMD_W = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BYTES);
    localparam logic [CMD_W-1:0] LAST_CMD = CMD_W'(NUM_CMDS - 1);

    probe_state_t     state_q, state_d;
    logic [IDX_W-1:0] byte_idx_q;
    logic [CMD_W-1:0] cmd_idx_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_ID_XFER;
            ST_ID_XFER:  if (ack_i && byte_idx_q == LAST_IDX) state_d = ST_ID_GAP;
            ST_ID_GAP:   state_d = ST_DECIDE;
            ST_DECIDE:   state_d = match_i ? ST_CMD_XFER : ST_FINISH;
            ST_CMD_XFER: if (ack_i) state_d = ST_CMD_GAP;
            ST_CMD_GAP:  state_d = (cmd_idx_q == LAST_CMD) ? ST_FINISH : ST_CMD_XFER;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            byte_idx_q <= '0;
            cmd_idx_q  <= '0;
            ok_o       <= 1'b0;
            mfr_o      <= '0;
            type_o     <= '0;
            cap_o      <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        byte_idx_q <= '0;
                        cmd_idx_q  <= '0;
                        ok_o       <= 1'b0;
                    end
                end
                ST_ID_XFER: begin
                    if (ack_i) begin
                        byte_idx_q <= byte_idx_q + 1'b1;
                        if (byte_idx_q == IDX_W'(1)) mfr_o  <= rx_i;
                        if (byte_idx_q == IDX_W'(2)) type_o <= rx_i;
                        if (byte_idx_q == IDX_W'(3)) cap_o  <= rx_i;
                    end
                end
                ST_DECIDE:  ok_o <= match_i;
                ST_CMD_GAP: cmd_idx_q <= cmd_idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        req_o      = 1'b0;
        tx_o       = FILLER_BYTE;
        cs_n_o     = 1'b1;
        done_o     = 1'b0;
        load_ok_o  = 1'b0;
        load_err_o = 1'b0;
        unique case (state_q)
            ST_ID_XFER: begin
                req_o  = 1'b1;
                cs_n_o = 1'b0;
                tx_o   = (byte_idx_q == '0) ? OP_IDENTIFY : FILLER_BYTE;
            end
            ST_DECIDE: begin
                load_ok_o  = match_i;
                load_err_o = !match_i;
            end
            ST_CMD_XFER: begin
                req_o  = 1'b1;
                cs_n_o = 1'b0;
                tx_o   = unlock_opcode(cmd_idx_q);
            end
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_probe_ctrl.sv
module flash_probe_ctrl #(
    parameter int SECT_CNT_W = 12,
    parameter int PAGE_CNT_W = 16,
    parameter int SHIFT_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    output logic                  xfer_req_o,
    output logic [7:0]            xfer_tx_o,
    input  logic                  xfer_ack_i,
    input  logic [7:0]            xfer_rx_i,
    output logic                  cs_n_o,
    output logic                  done_o,
    output logic                  ok_o,
    output logic [SECT_CNT_W-1:0] sector_count_o,
    output logic [SHIFT_W-1:0]    sector_shift_o,
    output logic [PAGE_CNT_W-1:0] page_count_o,
    output logic [SHIFT_W-1:0]    page_shift_o
);
    localparam int SECT_SHIFT = 12;
    localparam int PAGE_SHIFT = 8;

    logic                  match, load_ok, load_err;
    logic [7:0]            mfr, mtype, cap;
    logic [SECT_CNT_W-1:0] dec_sect;
    logic [PAGE_CNT_W-1:0] dec_page;

    flash_probe_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ack_i      (xfer_ack_i),
        .rx_i       (xfer_rx_i),
        .match_i    (match),
        .req_o      (xfer_req_o),
        .tx_o       (xfer_tx_o),
        .cs_n_o     (cs_n_o),
        .done_o     (done_o),
        .ok_o       (ok_o),
        .load_ok_o  (load_ok),
        .load_err_o (load_err),
        .mfr_o      (mfr),
        .type_o     (mtype),
        .cap_o      (cap)
    );

    flash_id_decode #(
        .SECT_CNT_W (SECT_CNT_W),
        .PAGE_CNT_W (PAGE_CNT_W)
    ) u_dec (
        .mfr_i      (mfr),
        .type_i     (mtype),
        .cap_i      (cap),
        .match_o    (match),
        .sect_cnt_o (dec_sect),
        .page_cnt_o (dec_page)
    );

    flash_geom_hold #(
        .SECT_CNT_W (SECT_CNT_W),
        .PAGE_CNT_W (PAGE_CNT_W),
        .SHIFT_W    (SHIFT_W),
        .SECT_SHIFT (SECT_SHIFT),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_geom (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_ok_i    (load_ok),
        .load_err_i   (load_err),
        .sect_cnt_i   (dec_sect),
        .page_cnt_i   (dec_page),
        .sect_cnt_o   (sector_count_o),
        .sect_shift_o (sector_shift_o),
        .page_cnt_o   (page_count_o),
        .page_shift_o (page_shift_o)
    );

endmodule

// File: rtl/flash_probe_ctrl_chk.sv
module flash_probe_ctrl_chk #(
    parameter int SECT_CNT_W = 12,
    parameter int PAGE_CNT_W = 16,
    parameter int SHIFT_W    = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  xfer_req_o,
    input logic [7:0]            xfer_tx_o,
    input logic                  xfer_ack_i,
    input logic                  cs_n_o,
    input logic                  done_o,
    input logic                  ok_o,
    input logic [SECT_CNT_W-1:0] sector_count_o,
    input logic [SHIFT_W-1:0]    sector_shift_o,
    input logic [PAGE_CNT_W-1:0] page_count_o,
    input logic [SHIFT_W-1:0]    page_shift_o
);
    AST_REQ_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> !cs_n_o); // R10

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_tx_o))); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !xfer_req_o)); // R7

    AST_FAIL_GEOM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> (sector_count_o == '0 && page_count_o == '0)); // R4

    AST_PASS_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> (sector_shift_o == SHIFT_W'(12) && page_shift_o == SHIFT_W'(8))); // R5

endmodule

bind flash_probe_ctrl flash_probe_ctrl_chk #(
    .SECT_CNT_W (SECT_CNT_W),
    .PAGE_CNT_W (PAGE_CNT_W),
    .SHIFT_W    (SHIFT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .xfer_req_o     (xfer_req_o),
    .xfer_tx_o      (xfer_tx_o),
    .xfer_ack_i     (xfer_ack_i),
    .cs_n_o         (cs_n_o),
    .done_o         (done_o),
    .ok_o           (ok_o),
    .sector_count_o (sector_count_o),
    .sector_shift_o (sector_shift_o),
    .page_count_o   (page_count_o),
    .page_shift_o   (page_shift_o)
);

// File: tb/flash_probe_ctrl_tb.sv
`timescale 1ns/1ps
module flash_probe_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_drv = 1'b0;
    logic        poke_drv = 1'b0;
    logic        start_i;
    logic        xfer_req_o;
    logic [7:0]  xfer_tx_o;
    logic        xfer_ack_i = 1'b0;
    logic [7:0]  xfer_rx_i = 8'h00;
    logic        cs_n_o, done_o, ok_o;
    logic [11:0] sector_count_o;
    logic [3:0]  sector_shift_o, page_shift_o;
    logic [15:0] page_count_o;

    int n_checks = 0;
    int n_fails  = 0;

    // serializer model state
    int         exp_q[$];
    logic [7:0] resp[4];
    int         lat = 0;
    int         lat_cnt = 0;
    int         fidx = 0;
    logic       prev_cs = 1'b1;
    bit         poke_en = 1'b0;
    bit         model_on = 1'b0;

    assign start_i = start_drv | poke_drv;

    always #10 clk = ~clk;

    flash_probe_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .xfer_req_o     (xfer_req_o),
        .xfer_tx_o      (xfer_tx_o),
        .xfer_ack_i     (xfer_ack_i),
        .xfer_rx_i      (xfer_rx_i),
        .cs_n_o         (cs_n_o),
        .done_o         (done_o),
        .ok_o           (ok_o),
        .sector_count_o (sector_count_o),
        .sector_shift_o (sector_shift_o),
        .page_count_o   (page_count_o),
        .page_shift_o   (page_shift_o)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Serializer and frame model, compared every clock away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            chk(!xfer_req_o || !cs_n_o, "R10 req outside frame", int'(cs_n_o), 0);
            if (prev_cs && !cs_n_o) fidx = 0;
            if (!prev_cs && cs_n_o) begin
                chk(exp_q.size() > 0 && exp_q[0] == -1, "R7 frame end", exp_q.size(), -1);
                if (exp_q.size() > 0) void'(exp_q.pop_front());
            end
            prev_cs = cs_n_o;
            poke_drv = poke_en && !cs_n_o;
            if (xfer_ack_i) begin
                xfer_ack_i = 1'b0;
            end else if (xfer_req_o && !cs_n_o) begin
                if (lat_cnt >= lat) begin
                    if (exp_q.size() > 0)
                        chk(int'(xfer_tx_o) == exp_q[0], "R2/R7 tx byte", int'(xfer_tx_o), exp_q[0]);
                    else
                        chk(1'b0, "R4/R6 unexpected byte", int'(xfer_tx_o), -1);
                    if (exp_q.size() > 0) void'(exp_q.pop_front());
                    xfer_rx_i  = (fidx < 4) ? resp[fidx] : 8'h00;
                    fidx++;
                    xfer_ack_i = 1'b1;
                    lat_cnt    = 0;
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    task automatic run(input logic [7:0] mfr, input logic [7:0] typ, input logic [7:0] cap,
                       input int latency, input bit poke, input bit exp_ok,
                       input int exp_sect, input int exp_page, input string tag);
        bit seen = 0;
        resp[0] = 8'h00; resp[1] = mfr; resp[2] = typ; resp[3] = cap;
        lat = latency; lat_cnt = 0;
        exp_q = {32'h9F, 32'hA5, 32'hA5, 32'hA5, -1};
        if (exp_ok) exp_q = {exp_q, 32'h06, -1, 32'h98, -1, 32'h04, -1};
        @(negedge clk);
        chk(cs_n_o == 1'b1, {"R1 cs idle before ", tag}, int'(cs_n_o), 1);
        start_drv = 1'b1;
        poke_en   = poke;
        @(negedge clk);
        start_drv = 1'b0;
        for (int c = 0; c < 2000 && !seen; c++) begin
            if (done_o) seen = 1;
            else @(negedge clk);
        end
        poke_en = 1'b0;
        chk(seen, {"R8 done seen ", tag}, int'(seen), 1);
        if (seen) begin
            chk(exp_q.size() == 0, {"R4/R6/R7 frames complete ", tag}, exp_q.size(), 0);
            chk(ok_o == exp_ok, {"R8 ok at done ", tag}, int'(ok_o), int'(exp_ok));
            chk(int'(sector_count_o) == exp_sect, {"R5/R11 sectors ", tag}, int'(sector_count_o), exp_sect);
            chk(int'(page_count_o) == exp_page, {"R5/R11 pages ", tag}, int'(page_count_o), exp_page);
            chk(int'(sector_shift_o) == (exp_ok ? 12 : 0), {"R5 sector shift ", tag}, int'(sector_shift_o), exp_ok ? 12 : 0);
            chk(int'(page_shift_o) == (exp_ok ? 8 : 0), {"R5 page shift ", tag}, int'(page_shift_o), exp_ok ? 8 : 0);
            @(negedge clk);
            chk(done_o == 1'b0, {"R8 done one cycle ", tag}, int'(done_o), 0);
            repeat (4) @(negedge clk);
            chk(ok_o == exp_ok, {"R8 ok held ", tag}, int'(ok_o), int'(exp_ok));
            chk(cs_n_o == 1'b1, {"R1 cs idle after ", tag}, int'(cs_n_o), 1);
        end
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1 && xfer_req_o == 1'b0, "R1 reset cs/req", int'(cs_n_o), 1);
        chk(done_o == 1'b0 && ok_o == 1'b0, "R1 reset done/ok", int'(ok_o), 0);
        chk(sector_count_o == 0 && page_count_o == 0 && sector_shift_o == 0 && page_shift_o == 0,
            "R1 reset geometry", int'(sector_count_o), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        // R2 R3 R5 R7: smallest size, immediate acknowledge
        run(8'hBF, 8'h26, 8'h41, 0, 1'b0, 1'b1, 512, 8192, "cap41");
        // R9: start pulses injected throughout the busy window
        run(8'hBF, 8'h26, 8'h42, 2, 1'b1, 1'b1, 1024, 16384, "cap42 poked");
        // R11: idle interval keeps geometry
        repeat (20) @(negedge clk);
        chk(sector_count_o == 1024 && page_count_o == 16384, "R11 hold while idle", int'(sector_count_o), 1024);
        run(8'hBF, 8'h26, 8'h43, 1, 1'b0, 1'b1, 2048, 32768, "cap43");
        // R4: wrong manufacturer, wrong type
        run(8'hC2, 8'h26, 8'h42, 1, 1'b0, 1'b0, 0, 0, "bad mfr");
        run(8'hBF, 8'h25, 8'h42, 0, 1'b1, 1'b0, 0, 0, "bad type");
        // R6: capacity codes just outside the known range
        run(8'hBF, 8'h26, 8'h44, 3, 1'b0, 1'b0, 0, 0, "cap44");
        run(8'hBF, 8'h26, 8'h40, 0, 1'b0, 1'b0, 0, 0, "cap40");
        // R11: recovery after an error
        run(8'hBF, 8'h26, 8'h42, 0, 1'b0, 1'b1, 1024, 16384, "recover");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule